// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

The block drives three complementary pairs of gate signals for a three-phase inverter. A single up/down counter sets the switching rhythm for all six outputs. Each phase compares that count against its own duty value to place two pulses, one on each side of the period center. Dead time is cut from both edges of every pulse, so the high-side and low-side switches of a pair are never on together. Any pulse that would be shorter than a programmed minimum is dropped entirely.

The configuration arrives as plain input vectors. It is copied into an active set only at update points: the period start, and also the period midpoint when double-update mode is selected. Several stages act on the raw pulses:
- A per-phase crossover swaps the two sides of a pair.
- A free-running carrier can chop the high-side outputs, the low-side outputs, or both.
- Each of the six outputs has its own enable.
- An active-low trip input forces all six outputs low without waiting for a clock edge. The off state is held in a latched flag until it is cleared.

A sync pulse marks the middle of every period.

Top module: `tri_pwm_gen`

## Requirements
- R1: One switching period lasts 2*half_period_i clock cycles in single-update mode, and sync_o rises exactly once per period.
- R2: With 0 <= duty <= half period, over one period the high-side output gate_o[2p] is on for 2*(duty-dead) cycles and the low-side output gate_o[2p+1] for 2*(half_period-duty-dead) cycles, each split evenly around the period center.
- R3: The two outputs of a pair are never on in the same cycle; over one period the pair is fully off for 2*half_period minus the two on-times, which is 4*dead when both pulses are kept.
- R4: A pulse whose per-half width is zero, negative or less than min_pulse_i is removed and that output stays 0 for the whole period; a width equal to min_pulse_i is kept.
- R5: sync_o is high for sync_width_i cycles (sync_width_i <= half period), starting with the first cycle of the second half of the period.
- R6: trip_ni low drives all six gate_o bits to 0 with no clock edge in between, and sets trip_flag_o.
- R7: After trip_ni returns high, gate_o stays 0 while trip_flag_o is 1. trip_clr_i clears the flag at a clock edge only while trip_ni is high, and is ignored while trip_ni is low.
- R8: xover_i[p] = 1 exchanges the high-side and low-side signals of phase p on gate_o[2p] and gate_o[2p+1].
- R9: out_en_i[k] = 0 holds gate_o[k] at 0.
- R10: A carrier with period 4*(chop_div_i+1) cycles, with equal high and low runs of 2*(chop_div_i+1) cycles, gates the even (high-side) outputs when chop_hi_en_i = 1 and the odd (low-side) outputs when chop_lo_en_i = 1.
- R11: With dbl_upd_i = 0, a new half period applied during the first half of a period takes effect only at the next period start.
- R12: With dbl_upd_i = 1, settings are also taken at the period midpoint, and a period lasts the first-half half period plus the second-half half period.
- R13: While reset is held, gate_o, sync_o and trip_flag_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_period_i | input | CNT_W | Half-period length in cycles |
| dead_time_i | input | CNT_W | Dead time cut from each pulse edge |
| min_pulse_i | input | CNT_W | Minimum per-half pulse width |
| sync_width_i | input | CNT_W | Width of the midpoint sync pulse |
| duty_i | input | N_PH x CNT_W | Duty value for each phase |
| xover_i | input | N_PH | Per-phase high/low swap |
| out_en_i | input | 2*N_PH | Per-output enable |
| chop_hi_en_i | input | 1 | Chop the high-side outputs |
| chop_lo_en_i | input | 1 | Chop the low-side outputs |
| chop_div_i | input | CHOP_W | Carrier divider |
| dbl_upd_i | input | 1 | Also take settings at the midpoint |
| trip_ni | input | 1 | Asynchronous fault input, active low |
| trip_clr_i | input | 1 | Clears the latched trip |
| gate_o | output | 2*N_PH | Gate outputs; even bits are high side, odd bits low side |
| sync_o | output | 1 | Midpoint sync pulse |
| trip_flag_o | output | 1 | Latched trip status |

## Verification
The bench uses the default parameters: three phases, a 16-bit count and an 8-bit chop divider. This keeps half periods of a few dozen to about a hundred cycles within reach, so every run measures whole periods cycle by cycle. Random duty, dead-time and minimum-width mixes reach both sides of the pulse-deletion threshold, including the exact-equal width and a duty at the full half period. With short periods, a half-period change can be placed inside a chosen half. That separates start-only loading from midpoint loading by the sync interval alone.

// File: rtl/tri_pwm_pkg.sv
package tri_pwm_pkg;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} cnt_dir_e;
  // slot of each side inside a pair on the gate bus
  localparam int unsigned HI_SLOT = 0;
  localparam int unsigned LO_SLOT = 1;
endpackage

// File: rtl/tri_pwm_timebase.sv
module tri_pwm_timebase
  import tri_pwm_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] hp_act_i,
  input  logic [CNT_W-1:0] hp_new_i,
  input  logic             dbl_i,
  output logic [CNT_W-1:0] cnt_o,
  output cnt_dir_e         dir_o,
  output logic             first_o,
  output logic             ld_start_o,
  output logic             ld_mid_o
);
  logic [CNT_W-1:0] cnt_q;
  cnt_dir_e         dir_q;
  logic             first_q;
  logic [CNT_W:0]   cnt_inc;
  logic             at_top, at_end;

  always_comb begin
    cnt_inc = {1'b0, cnt_q} + 1'b1;
    at_top  = !first_q && (dir_q == DIR_UP) && (cnt_inc >= {1'b0, hp_act_i});
    at_end  = (dir_q == DIR_DOWN) && (cnt_q == '0);
  end

  assign ld_start_o = first_q || at_end;
  assign ld_mid_o   = at_top && dbl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      dir_q   <= DIR_UP;
      first_q <= 1'b1;
    end else if (ld_start_o) begin
      cnt_q   <= '0;
      dir_q   <= DIR_UP;
      first_q <= 1'b0;
    end else if (at_top) begin
      dir_q <= DIR_DOWN;
      // second half restarts from the newly taken half period
      if (dbl_i) cnt_q <= (hp_new_i == '0) ? '0 : hp_new_i - 1'b1;
    end else if (dir_q == DIR_UP) begin
      cnt_q <= cnt_inc[CNT_W-1:0];
    end else begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o   = cnt_q;
  assign dir_o   = dir_q;
  assign first_o = first_q;
endmodule

// File: rtl/tri_pwm_phase.sv
module tri_pwm_phase #(
  parameter int unsigned CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] hp_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] dead_i,
  input  logic [CNT_W-1:0] minw_i,
  output logic             hi_o,
  output logic             lo_o
);
  localparam int unsigned SW = CNT_W + 3;

  logic signed [SW-1:0] s_cnt, s_hp, s_duty, s_dead, s_min;
  logic signed [SW-1:0] hi_w, lo_w, hi_th;
  logic                 hi_keep, lo_keep;

  always_comb begin
    s_cnt  = $signed({3'b000, cnt_i});
    s_hp   = $signed({3'b000, hp_i});
    s_duty = $signed({3'b000, duty_i});
    s_dead = $signed({3'b000, dead_i});
    s_min  = $signed({3'b000, minw_i});
    hi_w   = s_duty - s_dead;
    lo_w   = s_hp - s_duty - s_dead;
    hi_th  = s_hp - hi_w;
    hi_keep = !hi_w[SW-1] && (hi_w != '0) && (hi_w >= s_min);
    lo_keep = !lo_w[SW-1] && (lo_w != '0) && (lo_w >= s_min);
    hi_o   = hi_keep && (s_cnt >= hi_th);
    lo_o   = lo_keep && (s_cnt < lo_w);
  end
endmodule

// File: rtl/tri_pwm_chopper.sv
module tri_pwm_chopper #(
  parameter int unsigned CHOP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CHOP_W-1:0] div_i,
  output logic              carrier_o
);
  localparam int unsigned PW = CHOP_W + 1;

  logic [PW-1:0] cnt_q;
  logic [PW-1:0] last;
  logic          car_q;

  assign last = {div_i, 1'b1};  // run of 2*(div+1) cycles

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      car_q <= 1'b1;
    end else if (cnt_q >= last) begin
      cnt_q <= '0;
      car_q <= ~car_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign carrier_o = car_q;
endmodule

// File: rtl/tri_pwm_gen.sv
module tri_pwm_gen
  import tri_pwm_pkg::*;
#(
  parameter int unsigned N_PH   = 3,
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned CHOP_W = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [CNT_W-1:0]           half_period_i,
  input  logic [CNT_W-1:0]           dead_time_i,
  input  logic [CNT_W-1:0]           min_pulse_i,
  input  logic [CNT_W-1:0]           sync_width_i,
  input  logic [N_PH-1:0][CNT_W-1:0] duty_i,
  input  logic [N_PH-1:0]            xover_i,
  input  logic [2*N_PH-1:0]          out_en_i,
  input  logic                       chop_hi_en_i,
  input  logic                       chop_lo_en_i,
  input  logic [CHOP_W-1:0]          chop_div_i,
  input  logic                       dbl_upd_i,
  input  logic                       trip_ni,
  input  logic                       trip_clr_i,
  output logic [2*N_PH-1:0]          gate_o,
  output logic                       sync_o,
  output logic                       trip_flag_o
);
  localparam int unsigned N_OUT = 2 * N_PH;

  // active settings
  logic [CNT_W-1:0]           hp_q, dead_q, min_q, sw_q;
  logic [N_PH-1:0][CNT_W-1:0] duty_q;
  logic [N_PH-1:0]            xover_q;
  logic [N_OUT-1:0]           en_q;
  logic                       chop_hi_q, chop_lo_q;
  logic [CHOP_W-1:0]          chop_div_q;

  logic [CNT_W-1:0] tb_cnt;
  cnt_dir_e         tb_dir;
  logic             tb_down, tb_first, ld_start, ld_mid, ld_any;
  logic             carrier, trip_q;
  logic [N_PH-1:0]  hi_raw, lo_raw;
  logic [N_OUT-1:0] core;
  logic [CNT_W:0]   sync_dist;

  tri_pwm_timebase #(.CNT_W(CNT_W)) u_tbase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .hp_act_i   (hp_q),
    .hp_new_i   (half_period_i),
    .dbl_i      (dbl_upd_i),
    .cnt_o      (tb_cnt),
    .dir_o      (tb_dir),
    .first_o    (tb_first),
    .ld_start_o (ld_start),
    .ld_mid_o   (ld_mid)
  );

  assign tb_down = (tb_dir == DIR_DOWN);
  assign ld_any  = ld_start || ld_mid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hp_q       <= '0;
      dead_q     <= '0;
      min_q      <= '0;
      sw_q       <= '0;
      duty_q     <= '0;
      xover_q    <= '0;
      en_q       <= '0;
      chop_hi_q  <= 1'b0;
      chop_lo_q  <= 1'b0;
      chop_div_q <= '0;
    end else if (ld_any) begin
      hp_q       <= half_period_i;
      dead_q     <= dead_time_i;
      min_q      <= min_pulse_i;
      sw_q       <= sync_width_i;
      duty_q     <= duty_i;
      xover_q    <= xover_i;
      en_q       <= out_en_i;
      chop_hi_q  <= chop_hi_en_i;
      chop_lo_q  <= chop_lo_en_i;
      chop_div_q <= chop_div_i;
    end
  end

  for (genvar p = 0; p < N_PH; p++) begin : g_phase
    tri_pwm_phase #(.CNT_W(CNT_W)) u_phase (
      .cnt_i  (tb_cnt),
      .hp_i   (hp_q),
      .duty_i (duty_q[p]),
      .dead_i (dead_q),
      .minw_i (min_q),
      .hi_o   (hi_raw[p]),
      .lo_o   (lo_raw[p])
    );

    logic hi_x, lo_x;
    assign hi_x = xover_q[p] ? lo_raw[p] : hi_raw[p];
    assign lo_x = xover_q[p] ? hi_raw[p] : lo_raw[p];
    assign core[2*p+HI_SLOT] = hi_x && (carrier || !chop_hi_q) && en_q[2*p+HI_SLOT];
    assign core[2*p+LO_SLOT] = lo_x && (carrier || !chop_lo_q) && en_q[2*p+LO_SLOT];
  end

  tri_pwm_chopper #(.CHOP_W(CHOP_W)) u_chop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (chop_div_q),
    .carrier_o (carrier)
  );

  // cycles elapsed in the second half
  always_comb begin
    sync_dist = {1'b0, hp_q} - {1'b0, tb_cnt} - 1'b1;
    sync_o    = tb_down && !tb_first && !sync_dist[CNT_W] &&
                (sync_dist[CNT_W-1:0] < sw_q);
  end

  // trip latch: set asynchronously by the fault pin
  always_ff @(posedge clk_i or negedge rst_ni or negedge trip_ni) begin
    if (!rst_ni)         trip_q <= 1'b0;
    else if (!trip_ni)   trip_q <= 1'b1;
    else if (trip_clr_i) trip_q <= 1'b0;
  end

  assign trip_flag_o = trip_q;
  assign gate_o      = core & {N_OUT{trip_ni && !trip_q}};
endmodule

module tri_pwm_gen_chk #(
  parameter int unsigned N_PH  = 3,
  parameter int unsigned CNT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trip_ni,
  input logic [2*N_PH-1:0] gate_i,
  input logic              sync_i,
  input logic              trip_flag_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic [CNT_W-1:0]  hp_i,
  input logic              down_i,
  input logic              first_i
);
  for (genvar p = 0; p < N_PH; p++) begin : g_pair
    p_no_overlap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(gate_i[2*p] && gate_i[2*p+1]));
  end

  p_trip_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_ni |-> (gate_i == '0));

  p_trip_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_ni |=> trip_flag_i);

  p_trip_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_flag_i |-> (gate_i == '0));

  p_sync_second_half_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_i |-> down_i);

  p_cnt_range_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!first_i && (hp_i != '0)) |-> (cnt_i < hp_i));
endmodule

bind tri_pwm_gen tri_pwm_gen_chk #(.N_PH(N_PH), .CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .trip_ni     (trip_ni),
  .gate_i      (gate_o),
  .sync_i      (sync_o),
  .trip_flag_i (trip_flag_o),
  .cnt_i       (tb_cnt),
  .hp_i        (hp_q),
  .down_i      (tb_down),
  .first_i     (tb_first)
);

// File: tb/tri_pwm_gen_tb.sv
module tri_pwm_gen_tb;
  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [15:0]      half_period_i = 16'd0;
  logic [15:0]      dead_time_i = 16'd0;
  logic [15:0]      min_pulse_i = 16'd0;
  logic [15:0]      sync_width_i = 16'd1;
  logic [2:0][15:0] duty_i = '0;
  logic [2:0]       xover_i = '0;
  logic [5:0]       out_en_i = 6'b111111;
  logic             chop_hi_en_i = 1'b0;
  logic             chop_lo_en_i = 1'b0;
  logic [7:0]       chop_div_i = 8'd0;
  logic             dbl_upd_i = 1'b0;
  logic             trip_ni = 1'b1;
  logic             trip_clr_i = 1'b0;
  logic [5:0]       gate_o;
  logic             sync_o;
  logic             trip_flag_o;

  int n_chk = 0;
  int n_err = 0;
  int cur_hp = 0;
  int cnt_g[6];
  int cnt_dead[3];
  int cnt_ovl[3];
  int cnt_sync;

  always #4 clk = ~clk;

  tri_pwm_gen u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .half_period_i (half_period_i),
    .dead_time_i   (dead_time_i),
    .min_pulse_i   (min_pulse_i),
    .sync_width_i  (sync_width_i),
    .duty_i        (duty_i),
    .xover_i       (xover_i),
    .out_en_i      (out_en_i),
    .chop_hi_en_i  (chop_hi_en_i),
    .chop_lo_en_i  (chop_lo_en_i),
    .chop_div_i    (chop_div_i),
    .dbl_upd_i     (dbl_upd_i),
    .trip_ni       (trip_ni),
    .trip_clr_i    (trip_clr_i),
    .gate_o        (gate_o),
    .sync_o        (sync_o),
    .trip_flag_o   (trip_flag_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_hi(int hp, int duty, int dt, int mn);
    int w = duty - dt;
    return (w > 0 && w >= mn) ? 2 * w : 0;
  endfunction

  function automatic int exp_lo(int hp, int duty, int dt, int mn);
    int w = hp - duty - dt;
    return (w > 0 && w >= mn) ? 2 * w : 0;
  endfunction

  task automatic wait_sync_rise();
    logic prev = 1'b1;
    while (1) begin
      @(negedge clk);
      if (sync_o && !prev) break;
      prev = sync_o;
    end
  endtask

  task automatic sync_interval(output int d);
    logic prev = 1'b1;
    d = 0;
    while (1) begin
      @(negedge clk);
      d++;
      if (sync_o && !prev) break;
      prev = sync_o;
    end
  endtask

  task automatic set_cfg(input int hp, input int dt, input int mn, input int sw,
                         input int da, input int db, input int dc);
    half_period_i = 16'(hp);
    dead_time_i   = 16'(dt);
    min_pulse_i   = 16'(mn);
    sync_width_i  = 16'(sw);
    duty_i[0]     = 16'(da);
    duty_i[1]     = 16'(db);
    duty_i[2]     = 16'(dc);
    repeat (2 * (cur_hp + hp) + 8) @(negedge clk);
    cur_hp = hp;
  endtask

  task automatic measure(input int n);
    for (int k = 0; k < 6; k++) cnt_g[k] = 0;
    for (int p = 0; p < 3; p++) begin cnt_dead[p] = 0; cnt_ovl[p] = 0; end
    cnt_sync = 0;
    wait_sync_rise();
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < 6; k++) if (gate_o[k]) cnt_g[k]++;
      for (int p = 0; p < 3; p++) begin
        if (!gate_o[2*p] && !gate_o[2*p+1]) cnt_dead[p]++;
        if (gate_o[2*p] && gate_o[2*p+1]) cnt_ovl[p]++;
      end
      if (sync_o) cnt_sync++;
      @(negedge clk);
    end
  endtask

  task automatic run_case(input int hp, input int dt, input int mn, input int sw,
                          input int da, input int db, input int dc);
    int d[3];
    int eh, el, itv;
    d[0] = da; d[1] = db; d[2] = dc;
    set_cfg(hp, dt, mn, sw, da, db, dc);
    wait_sync_rise();
    sync_interval(itv);
    chk(itv == 2 * hp, "R1 period", itv, 2 * hp);
    measure(2 * hp);
    chk(cnt_sync == sw, "R5 sync width", cnt_sync, sw);
    for (int p = 0; p < 3; p++) begin
      eh = exp_hi(hp, d[p], dt, mn);
      el = exp_lo(hp, d[p], dt, mn);
      if (xover_i[p]) begin
        chk(cnt_g[2*p] == el, "R8 swapped high slot", cnt_g[2*p], el);
        chk(cnt_g[2*p+1] == eh, "R8 swapped low slot", cnt_g[2*p+1], eh);
      end else begin
        chk(cnt_g[2*p] == eh, "R2/R4 high side", cnt_g[2*p], eh);
        chk(cnt_g[2*p+1] == el, "R2/R4 low side", cnt_g[2*p+1], el);
      end
      chk(cnt_ovl[p] == 0, "R3 overlap", cnt_ovl[p], 0);
      chk(cnt_dead[p] == 2 * hp - eh - el, "R3 off time", cnt_dead[p], 2 * hp - eh - el);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int hp, dt, mn, ln, hrun, lrun, itv;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R13 reset state
    chk(gate_o == 6'b0, "R13 gate in reset", int'(gate_o), 0);
    chk(sync_o == 1'b0, "R13 sync in reset", int'(sync_o), 0);
    chk(trip_flag_o == 1'b0, "R13 trip flag in reset", int'(trip_flag_o), 0);
    rst_ni = 1'b1;

    // R4 directed: width below, equal to min, and low side removed at full duty
    run_case(50, 3, 5, 4, 7, 8, 50);
    run_case(40, 0, 0, 40, 20, 0, 40);

    // random mixes
    for (int it = 0; it < 8; it++) begin
      hp = $urandom_range(116, 16);
      dt = $urandom_range(5, 0);
      mn = $urandom_range(7, 0);
      xover_i = (it == 5) ? 3'b010 : 3'b000;  // R8 in one mix
      run_case(hp, dt, mn, $urandom_range(hp, 1), $urandom_range(hp, 0),
               $urandom_range(hp, 0), $urandom_range(hp, 0));
    end
    xover_i = 3'b000;

    // R9 enables, full high-side duty
    out_en_i = 6'b111110;
    set_cfg(30, 0, 0, 1, 30, 30, 30);
    chk(gate_o[0] == 1'b0, "R9 disabled output", int'(gate_o[0]), 0);
    chk(gate_o[2] == 1'b1, "R9 enabled output", int'(gate_o[2]), 1);
    out_en_i = 6'b111111;
    repeat (70) @(negedge clk);
    chk(gate_o == 6'b010101, "R2 full duty", int'(gate_o), 21);

    // R6 asynchronous trip, R7 latch and clear
    @(negedge clk);
    #1 trip_ni = 1'b0;
    #1 chk(gate_o == 6'b0, "R6 immediate off", int'(gate_o), 0);
    @(negedge clk);
    chk(trip_flag_o == 1'b1, "R6 flag set", int'(trip_flag_o), 1);
    trip_clr_i = 1'b1;
    @(negedge clk);
    trip_clr_i = 1'b0;
    trip_ni = 1'b1;
    repeat (70) @(negedge clk);
    chk(trip_flag_o == 1'b1, "R7 clear ignored while low", int'(trip_flag_o), 1);
    chk(gate_o == 6'b0, "R7 held off", int'(gate_o), 0);
    trip_clr_i = 1'b1;
    @(negedge clk);
    trip_clr_i = 1'b0;
    chk(trip_flag_o == 1'b0, "R7 flag cleared", int'(trip_flag_o), 0);
    chk(gate_o == 6'b010101, "R7 outputs resume", int'(gate_o), 21);

    // R10 chopping on high side, div = 2
    chop_hi_en_i = 1'b1;
    chop_div_i = 8'd2;
    repeat (130) @(negedge clk);
    while (gate_o[0]) @(negedge clk);
    while (!gate_o[0]) @(negedge clk);
    hrun = 0;
    while (gate_o[0]) begin hrun++; @(negedge clk); end
    lrun = 0;
    while (!gate_o[0]) begin lrun++; @(negedge clk); end
    chk(hrun == 6, "R10 carrier high run", hrun, 6);
    chk(lrun == 6, "R10 carrier low run", lrun, 6);
    // R10 low side through crossover, div = 0
    chop_hi_en_i = 1'b0;
    chop_lo_en_i = 1'b1;
    chop_div_i = 8'd0;
    xover_i = 3'b001;
    repeat (130) @(negedge clk);
    while (gate_o[1]) @(negedge clk);
    while (!gate_o[1]) @(negedge clk);
    hrun = 0;
    while (gate_o[1]) begin hrun++; @(negedge clk); end
    chk(hrun == 2, "R10 low-side carrier run", hrun, 2);
    chk(gate_o[0] == 1'b0, "R8 swapped high slot off", int'(gate_o[0]), 0);
    chop_lo_en_i = 1'b0;
    xover_i = 3'b000;

    // R11 single update: change during first half of a period
    set_cfg(40, 2, 0, 1, 20, 20, 20);
    wait_sync_rise();
    repeat (60) @(negedge clk);
    half_period_i = 16'd24;
    wait_sync_rise();
    sync_interval(itv);
    chk(itv == 64, "R11 start-only update", itv, 64);
    cur_hp = 24;

    // R12 double update
    dbl_upd_i = 1'b1;
    set_cfg(40, 2, 0, 1, 20, 20, 20);
    wait_sync_rise();
    repeat (60) @(negedge clk);
    half_period_i = 16'd24;
    wait_sync_rise();
    sync_interval(itv);
    chk(itv == 48, "R12 midpoint update", itv, 48);
    cur_hp = 24;
    duty_i = '0;
    set_cfg(24, 2, 0, 1, 12, 12, 12);
    measure(48);
    chk(cnt_g[0] == 20, "R12 high side in double mode", cnt_g[0], 20);
    dbl_upd_i = 1'b0;

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule